// File: doc/BRIEF.md
# Serial Stream Capture Buffer with SPI Burst Output

This block takes in a continuous one-bit data stream that arrives on its own bit clock. It gathers the stream into frames of `FRAME_BITS` bits, 192 by default. Each complete frame is handed across to an unrelated system clock, where an SPI master shifts it out to a host as one burst, with chip select held low for the whole burst. Capture never pauses. While one frame is on the wire, the next one fills in the second of two frame stores.

On the capture side, a serial-to-parallel shifter and a bit counter run in the bit-clock domain. At the end of each frame, the finished word is copied into the frame store chosen by a write pointer that alternates between the two stores. A toggle then announces the frame. Two flip-flops carry that toggle into the system domain, where an edge detector turns it into a single-cycle frame event. The transmit state machine copies the newest frame into a parallel-to-serial shifter and clocks it out in SPI mode 0: the clock idles low, data is set up while the clock is low, and the host samples on the rising edge. The earliest captured bit goes first. `SCK_HALF` sets the serial clock half-period in system clock cycles.

The transmit state machine has five states:
- `TX_IDLE`: chip select is high.
- `TX_LEAD`: chip select is low and the first bit is driven.
- `TX_HIGH`: the clock is high.
- `TX_LOW`: the clock is low between bits.
- `TX_TAIL`: chip select is still low after the last bit.

Its transitions are:
- `TX_IDLE` to `TX_LEAD` when a frame is waiting.
- `TX_LEAD` to `TX_HIGH` after one half-period.
- `TX_HIGH` to `TX_LOW` after one half-period, for every bit except the last.
- `TX_HIGH` to `TX_TAIL` after the last bit's half-period.
- `TX_LOW` to `TX_HIGH` after one half-period.
- `TX_TAIL` to `TX_IDLE` after one half-period.

Top module: `ssc_frame_spi`

## Requirements
- R1: While both resets are asserted, `spi_cs_n` is 1 and `spi_sck`, `spi_mosi`, `frame_ready` and `overrun` are 0.
- R2: No burst starts until `FRAME_BITS` bits have been captured since reset or since the previous frame ended: after `FRAME_BITS-1` bits, `spi_cs_n` stays 1 and nothing is sent.
- R3: Each burst has exactly `FRAME_BITS` rising edges of `spi_sck`, all while `spi_cs_n` is 0. `spi_sck` is never 1 while `spi_cs_n` is 1.
- R4: SPI mode 0 is used: `spi_sck` idles at 0, and `spi_mosi` holds its value for the whole time `spi_sck` is 1.
- R5: Bits go out in capture order. The first bit captured in a frame is on `spi_mosi` at the first rising edge of `spi_sck`, and the last bit captured is on it at the last rising edge.
- R6: The first rising edge of `spi_sck` comes `SCK_HALF` system cycles after `spi_cs_n` falls. Later rising edges are `2*SCK_HALF` system cycles apart.
- R7: Capture continues while a burst is in progress. Frames sent back to back at a rate the burst can keep up with are all delivered, intact and in order.
- R8: `frame_ready` rises once for each completed frame that reaches the system domain. It stays 1 until that frame's burst starts. When frames arrive while the previous burst is still running, it stays 1 for the rest of that burst.
- R9: A frame that completes while another completed frame is still waiting to start sets `overrun` to 1, and it stays 1 until system reset. The older waiting frame is discarded, and the newest frame is the one sent next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock of the incoming serial stream |
| bit_rst | input | 1 | Synchronous reset, bit-clock domain |
| bit_din | input | 1 | Serial data, sampled on the rising edge of `bit_clk` |
| sys_clk | input | 1 | System clock for the SPI side |
| sys_rst | input | 1 | Synchronous reset, system domain |
| spi_sck | output | 1 | SPI serial clock (mode 0) |
| spi_mosi | output | 1 | SPI data out, earliest captured bit first |
| spi_cs_n | output | 1 | SPI chip select, active low, held for the whole burst |
| frame_ready | output | 1 | A completed frame is waiting to be sent |
| overrun | output | 1 | Sticky flag: a waiting frame was replaced by a newer one |

## Verification
Suppose the capture bit counter or the write pointer goes wrong. The next burst would then come after the wrong number of input bits, or would carry bits rotated or taken from a stale frame store, and the first mismatching frame shows this at the ports within one frame time. A fault in the transmit state machine or its half-period counter shows up sooner, at the first clock edge of the next burst: the clock spacing, the lead time after chip select, the number of clocks in the burst, or the stability of data while the clock is high would be wrong. An error in the waiting-frame or overrun logic shows up as a wrong `frame_ready` edge count, an `overrun` flag that is set or missing, or the wrong frame sent after an overload.

// File: rtl/ssc_pkg.sv
`timescale 1ns/1ps
package ssc_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_LEAD,
        TX_HIGH,
        TX_LOW,
        TX_TAIL
    } tx_state_t;

endpackage

// File: rtl/ssc_capture.sv
`timescale 1ns/1ps
module ssc_capture #(
    parameter int FRAME_BITS = 192
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         din,
    output logic [1:0][FRAME_BITS-1:0]   banks,
    output logic                         frame_tog
);
    localparam int CW = $clog2(FRAME_BITS);

    logic [FRAME_BITS-1:0] shift_q;
    logic [CW-1:0]         cnt_q;
    logic                  wr_sel_q;
    logic                  frame_done;
    logic [FRAME_BITS-1:0] frame_word;

    assign frame_done = (cnt_q == CW'(FRAME_BITS - 1));
    assign frame_word = {shift_q[FRAME_BITS-2:0], din};

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q   <= '0;
            cnt_q     <= '0;
            wr_sel_q  <= 1'b0;
            frame_tog <= 1'b0;
        end else begin
            shift_q <= frame_word;
            if (frame_done) begin
                cnt_q     <= '0;
                wr_sel_q  <= ~wr_sel_q;
                frame_tog <= ~frame_tog;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            banks <= '0;
        end else if (frame_done) begin
            for (int b = 0; b < 2; b++) begin
                if (wr_sel_q == 1'(b)) begin
                    banks[b] <= frame_word;
                end
            end
        end
    end

    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CW'(FRAME_BITS - 1)) |=> (cnt_q == '0));                 // R2
    AST_TOG_ON_FULL: assert property (@(posedge clk) disable iff (rst)
        !$stable(frame_tog) |-> ($past(cnt_q) == CW'(FRAME_BITS - 1)));     // R2

endmodule

// File: rtl/ssc_toggle_sync.sv
`timescale 1ns/1ps
module ssc_toggle_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tog_in,
    output logic pulse
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], tog_in};
        end
    end

    assign pulse = chain_q[STAGES] ^ chain_q[STAGES-1];

endmodule

// File: rtl/ssc_spi_tx.sv
`timescale 1ns/1ps
module ssc_spi_tx
    import ssc_pkg::*;
#(
    parameter int FRAME_BITS = 192,
    parameter int SCK_HALF   = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        frame_evt,
    input  logic [1:0][FRAME_BITS-1:0]  banks,
    output logic                        sck,
    output logic                        mosi,
    output logic                        cs_n,
    output logic                        frame_ready,
    output logic                        overrun
);
    localparam int BW = $clog2(FRAME_BITS);
    localparam int HW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

    tx_state_t             state_q, state_d;
    logic [HW-1:0]         cnt_q;
    logic [BW-1:0]         bit_idx_q;
    logic [FRAME_BITS-1:0] shreg_q;
    logic                  pending_q;
    logic                  newest_q;
    logic                  next_bank_q;
    logic                  overrun_q;
    logic                  half_done;
    logic                  last_bit;
    logic                  consume;

    assign half_done = (cnt_q == HW'(SCK_HALF - 1));
    assign last_bit  = (bit_idx_q == BW'(FRAME_BITS - 1));
    assign consume   = (state_q == TX_IDLE) && pending_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (pending_q) state_d = TX_LEAD;
            TX_LEAD: if (half_done) state_d = TX_HIGH;
            TX_HIGH: if (half_done) state_d = last_bit ? TX_TAIL : TX_LOW;
            TX_LOW:  if (half_done) state_d = TX_HIGH;
            TX_TAIL: if (half_done) state_d = TX_IDLE;
            default: state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q       <= '0;
            bit_idx_q   <= '0;
            shreg_q     <= '0;
            pending_q   <= 1'b0;
            newest_q    <= 1'b0;
            next_bank_q <= 1'b0;
            overrun_q   <= 1'b0;
        end else begin
            if (state_q == TX_IDLE || half_done) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + HW'(1);
            end

            if (consume) begin
                shreg_q   <= banks[newest_q];
                bit_idx_q <= '0;
            end else if (state_q == TX_HIGH && half_done && !last_bit) begin
                shreg_q   <= {shreg_q[FRAME_BITS-2:0], 1'b0};
                bit_idx_q <= bit_idx_q + BW'(1);
            end

            if (frame_evt) begin
                pending_q   <= 1'b1;
                newest_q    <= next_bank_q;
                next_bank_q <= ~next_bank_q;
                if (pending_q && !consume) begin
                    overrun_q <= 1'b1;
                end
            end else if (consume) begin
                pending_q <= 1'b0;
            end
        end
    end

    always_comb begin
        cs_n        = (state_q == TX_IDLE);
        sck         = (state_q == TX_HIGH);
        mosi        = (state_q == TX_IDLE) ? 1'b0 : shreg_q[FRAME_BITS-1];
        frame_ready = pending_q;
        overrun     = overrun_q;
    end

    AST_MOSI_STABLE: assert property (@(posedge clk) disable iff (rst)
        (sck && $past(sck)) |-> $stable(mosi));                             // R4
    AST_START_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> $past(pending_q));                                  // R2
    AST_FULL_BURST: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> ($past(bit_idx_q) == BW'(FRAME_BITS - 1)));          // R3
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(overrun) |-> overrun);                                        // R9
    AST_READY_TAKEN: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (!frame_ready || $past(frame_evt)));                // R8

endmodule

// File: rtl/ssc_frame_spi.sv
`timescale 1ns/1ps
module ssc_frame_spi #(
    parameter int FRAME_BITS  = 192,
    parameter int SCK_HALF    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic bit_clk,
    input  logic bit_rst,
    input  logic bit_din,
    input  logic sys_clk,
    input  logic sys_rst,
    output logic spi_sck,
    output logic spi_mosi,
    output logic spi_cs_n,
    output logic frame_ready,
    output logic overrun
);
    logic [1:0][FRAME_BITS-1:0] banks;
    logic                       frame_tog;
    logic                       frame_evt;

    ssc_capture #(.FRAME_BITS(FRAME_BITS)) u_capture (
        .clk       (bit_clk),
        .rst       (bit_rst),
        .din       (bit_din),
        .banks     (banks),
        .frame_tog (frame_tog)
    );

    ssc_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (sys_clk),
        .rst    (sys_rst),
        .tog_in (frame_tog),
        .pulse  (frame_evt)
    );

    ssc_spi_tx #(.FRAME_BITS(FRAME_BITS), .SCK_HALF(SCK_HALF)) u_tx (
        .clk         (sys_clk),
        .rst         (sys_rst),
        .frame_evt   (frame_evt),
        .banks       (banks),
        .sck         (spi_sck),
        .mosi        (spi_mosi),
        .cs_n        (spi_cs_n),
        .frame_ready (frame_ready),
        .overrun     (overrun)
    );

endmodule

// File: tb/ssc_frame_spi_test.sv
`timescale 1ns/1ps
module ssc_frame_spi_test;
    localparam int FB   = 192;
    localparam int HALF = 4;

    logic sys_clk = 1'b0, sys_rst = 1'b1;
    logic bit_clk = 1'b0, bit_rst = 1'b1, bit_din = 1'b0;
    logic spi_sck, spi_mosi, spi_cs_n, frame_ready, overrun;

    ssc_frame_spi #(.FRAME_BITS(FB), .SCK_HALF(HALF)) uut (
        .bit_clk(bit_clk), .bit_rst(bit_rst), .bit_din(bit_din),
        .sys_clk(sys_clk), .sys_rst(sys_rst),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
        .frame_ready(frame_ready), .overrun(overrun)
    );

    always #2.5 sys_clk = ~sys_clk;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s", req, msg);
        end
    endtask

    // behavioural reference: captured bits and completed frames
    bit              cur_bits[$];
    logic [FB-1:0]   all_frames[$];
    logic [FB-1:0]   rx_q[$];
    logic [15:0]     lfsr = 16'hACE1;

    task automatic send_bit(input bit b, input realtime half);
        logic [FB-1:0] f;
        bit_din = b;
        cur_bits.push_back(b);
        if (cur_bits.size() == FB) begin
            f = '0;
            for (int i = 0; i < FB; i++) f[FB-1-i] = cur_bits[i];
            all_frames.push_back(f);
            cur_bits.delete();
        end
        #half bit_clk = 1'b1;
        #half bit_clk = 1'b0;
    endtask

    task automatic send_frame(input int kind, input realtime half);
        for (int i = 0; i < FB; i++) begin
            bit b;
            case (kind)
                0: b = i[0];
                1: b = 1'b1;
                default: begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    b = lfsr[0];
                end
            endcase
            send_bit(b, half);
        end
    endtask

    task automatic wait_rx(input int n);
        wait (rx_q.size() >= n);
        #100;
    endtask

    // per-clock port monitor and protocol reference
    int cyc = 0, t_cs = 0, t_rise = 0, nb = 0, ready_rises = 0;
    bit first = 1'b0;
    logic p_sck = 1'b0, p_cs = 1'b1, p_ready = 1'b0, rise_mosi = 1'b0;
    logic [FB-1:0] rxf = '0;

    always @(negedge sys_clk) begin
        cyc++;
        if (!sys_rst && !done) begin
            chk(!(spi_cs_n && spi_sck), "R3",
                $sformatf("sck=%0b while cs_n=%0b, expected sck 0", spi_sck, spi_cs_n));
            if (p_cs && !spi_cs_n) begin
                t_cs = cyc; first = 1'b1; nb = 0; rxf = '0;
            end
            if (!p_sck && spi_sck) begin
                if (first)
                    chk(cyc - t_cs == HALF, "R6",
                        $sformatf("lead %0d expected %0d", cyc - t_cs, HALF));
                else
                    chk(cyc - t_rise == 2*HALF, "R6",
                        $sformatf("sck period %0d expected %0d", cyc - t_rise, 2*HALF));
                first = 1'b0;
                t_rise = cyc;
                rise_mosi = spi_mosi;
                rxf = {rxf[FB-2:0], spi_mosi};
                nb++;
            end else if (p_sck && spi_sck) begin
                chk(spi_mosi == rise_mosi, "R4",
                    $sformatf("mosi %0b expected %0b while sck high", spi_mosi, rise_mosi));
            end
            if (!p_cs && spi_cs_n) begin
                chk(nb == FB, "R3", $sformatf("burst edges %0d expected %0d", nb, FB));
                rx_q.push_back(rxf);
            end
            if (!p_ready && frame_ready) ready_rises++;
        end
        p_sck = spi_sck; p_cs = spi_cs_n; p_ready = frame_ready;
    end

    initial begin
        #500us;
        chk(1'b0, "WD", "watchdog expired, actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // reset both domains; bit clock pulsed so its synchronous reset takes
        for (int i = 0; i < 4; i++) begin
            #20 bit_clk = 1'b1;
            #20 bit_clk = 1'b0;
        end
        repeat (10) @(posedge sys_clk);
        @(negedge sys_clk);
        chk(spi_cs_n == 1'b1, "R1", $sformatf("cs_n %0b expected 1", spi_cs_n));
        chk(spi_sck == 1'b0, "R1", $sformatf("sck %0b expected 0", spi_sck));
        chk(spi_mosi == 1'b0, "R1", $sformatf("mosi %0b expected 0", spi_mosi));
        chk(frame_ready == 1'b0, "R1", $sformatf("frame_ready %0b expected 0", frame_ready));
        chk(overrun == 1'b0, "R1", $sformatf("overrun %0b expected 0", overrun));
        bit_rst = 1'b0;
        sys_rst = 1'b0;
        #37;

        // single one on the first bit, hold back the last bit
        send_bit(1'b1, 26.5);
        for (int i = 0; i < FB - 2; i++) send_bit(1'b0, 26.5);
        #3us;
        chk(spi_cs_n == 1'b1, "R2", $sformatf("cs_n %0b expected 1 after %0d bits", spi_cs_n, FB-1));
        chk(rx_q.size() == 0, "R2", $sformatf("bursts %0d expected 0", rx_q.size()));
        chk(frame_ready == 1'b0, "R2", $sformatf("frame_ready %0b expected 0", frame_ready));
        send_bit(1'b0, 26.5);
        wait_rx(1);
        chk(rx_q[0] == all_frames[0], "R5", $sformatf("frame0 %h expected %h", rx_q[0], all_frames[0]));
        chk(rx_q[0][FB-1] == 1'b1, "R5", $sformatf("first bit %0b expected 1", rx_q[0][FB-1]));

        // single one on the last bit
        for (int i = 0; i < FB - 1; i++) send_bit(1'b0, 26.5);
        send_bit(1'b1, 26.5);
        wait_rx(2);
        chk(rx_q[1] == all_frames[1], "R5", $sformatf("frame1 %h expected %h", rx_q[1], all_frames[1]));
        chk(rx_q[1][0] == 1'b1, "R5", $sformatf("last bit %0b expected 1", rx_q[1][0]));

        // three frames back to back, capture runs during each burst
        send_frame(0, 26.5);
        send_frame(2, 26.5);
        send_frame(1, 26.5);
        wait_rx(5);
        for (int i = 2; i < 5; i++)
            chk(rx_q[i] == all_frames[i], "R7",
                $sformatf("frame%0d %h expected %h", i, rx_q[i], all_frames[i]));
        chk(ready_rises == 5, "R8", $sformatf("frame_ready rises %0d expected 5", ready_rises));
        chk(overrun == 1'b0, "R9", $sformatf("overrun %0b expected 0", overrun));

        // overload: four frames far faster than a burst drains
        send_frame(2, 4.0);
        send_frame(2, 4.0);
        #50;
        chk(frame_ready == 1'b1, "R8", $sformatf("frame_ready %0b expected 1 during burst", frame_ready));
        chk(overrun == 1'b0, "R9", $sformatf("overrun %0b expected 0 with one waiting", overrun));
        send_frame(2, 4.0);
        #50;
        chk(overrun == 1'b1, "R9", $sformatf("overrun %0b expected 1", overrun));
        send_frame(2, 4.0);
        wait_rx(7);
        #12us;
        chk(rx_q.size() == 7, "R9", $sformatf("bursts %0d expected 7", rx_q.size()));
        chk(rx_q[5] == all_frames[5], "R9", $sformatf("frame5 %h expected %h", rx_q[5], all_frames[5]));
        chk(rx_q[6] == all_frames[8], "R9", $sformatf("frame6 %h expected newest %h", rx_q[6], all_frames[8]));
        chk(overrun == 1'b1, "R9", $sformatf("overrun %0b expected sticky 1", overrun));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule